// File: doc/BRIEF.md
# Serial Receive Holding Register with Status Flags

This block sits between a serial receive shifter and the CPU. When the shifter finishes a character it pulses a load strobe with the completed word. The block keeps that word and raises a receive-pending flag for the interrupt logic. When the CPU reads the word it pulses a read strobe, and that read also clears the pending flag and all error flags.

Three flags are kept: receive pending, overrun (a new word came in while the previous one was still unread) and frame error (the slave-select line changed while a character was being received). Characters can be 8 or 7 bits long. In 7-bit mode the top data bit is cleared when the word is stored, and it is also held at zero on the output. The CPU can write all three flags directly. A synchronous soft reset and the asynchronous chip reset both clear the whole block.

Top module: `rxbuf_status`

## Requirements
- R1: While `rst_ni` is low, `data_o` is 0 and `irq_o`, `ovr_o`, `frm_o` are all 0.
- R2: If `soft_rst_i` is high at a clock edge, the data register and all three flags are 0 after that edge, whatever the other inputs are.
- R3: If `load_i` is high at an edge, `data_o` shows `load_data_i` after that edge. The value is held until the next load or reset.
- R4: If `seven_bit_i` is high, `data_o[7]` is 0. A word loaded while `seven_bit_i` is high is stored with bit 7 cleared, so it still reads with bit 7 at 0 after the block returns to 8-bit mode.
- R5: `irq_o` goes to 1 on the same edge that stores a new word.
- R6: If a load arrives while `irq_o` is 1 and no read happens in that cycle, the new word replaces the old one and `ovr_o` goes to 1.
- R7: If `rd_i` is high at an edge and no set or write event applies in that cycle, `irq_o`, `ovr_o` and `frm_o` are all 0 after the edge.
- R8: If a load and a read happen in the same cycle, the new word is stored, `irq_o` stays 1 and `ovr_o` is not set.
- R9: If `sel_edge_i` is high at an edge, `frm_o` is 1 after it. This takes priority over clearing by a read in the same cycle.
- R10: If `flag_wr_i` is high at an edge, the flags take their values from `flag_wdata_i` (bit 0 is pending, bit 1 is overrun, bit 2 is frame error). A write takes priority over a read clear, and a hardware set event in the same cycle takes priority over the write.
- R11: A read never changes the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous software reset |
| load_i | input | 1 | Word-complete strobe from the shifter |
| load_data_i | input | 8 | Completed word |
| seven_bit_i | input | 1 | 1 selects 7-bit characters |
| sel_edge_i | input | 1 | Slave-select transition seen during reception |
| rd_i | input | 1 | CPU read strobe for the data register |
| flag_wr_i | input | 1 | CPU write strobe for the flags |
| flag_wdata_i | input | 3 | Flag write value {frame, overrun, pending} |
| data_o | output | 8 | Stored word |
| irq_o | output | 1 | Receive pending |
| ovr_o | output | 1 | Overrun error |
| frm_o | output | 1 | Frame error |

## Verification
The hardest cases to reach are the ones where several events land in the same cycle. These are a load together with a read, a slave-select edge together with a read, a flag write together with a load or a read, and a soft reset while every set source is active. Each of these depends on a priority order that single-event traffic never shows. The stimulus first builds a known flag state, such as pending and overrun both set, and then applies two or more strobes at once in one cycle. A separate case loads a word in 7-bit mode and then switches back to 8-bit mode. This shows whether bit 7 was cleared when the word was stored or only hidden on the output.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int unsigned NUM_FLAGS = 3;
  typedef enum int unsigned {
    FLAG_PEND = 0,
    FLAG_OVR  = 1,
    FLAG_FRM  = 2
  } flag_idx_e;
endpackage

// File: rtl/rxbuf_data.sv
module rxbuf_data #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SHORT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              short_i,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [DATA_W-1:0] SHORT_MASK = {{(DATA_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic [DATA_W-1:0] q;
  logic [DATA_W-1:0] mask;

  assign mask = short_i ? SHORT_MASK : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (srst_i) q <= '0;
    else if (load_i) q <= data_i & mask;
  end

  // mode can change after the load, so mask the output as well
  assign data_o = q & mask;
endmodule

// File: rtl/rxbuf_flag.sv
module rxbuf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic clr_i,
  output logic q_o
);
  // priority: soft reset > hardware set > cpu write > read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (srst_i) q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (wr_i)   q_o <= wdata_i;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status
  import rxbuf_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SHORT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              seven_bit_i,
  input  logic              sel_edge_i,
  input  logic              rd_i,
  input  logic              flag_wr_i,
  input  logic [2:0]        flag_wdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o,
  output logic              ovr_o,
  output logic              frm_o
);
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_q;

  rxbuf_data #(
    .DATA_W (DATA_W),
    .SHORT_W(SHORT_W)
  ) data_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (soft_rst_i),
    .load_i (load_i),
    .data_i (load_data_i),
    .short_i(seven_bit_i),
    .data_o (data_o)
  );

  // a read in the same cycle consumes the old word, so no overrun
  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_PEND] = load_i;
    flag_set[FLAG_OVR]  = load_i & flag_q[FLAG_PEND] & ~rd_i;
    flag_set[FLAG_FRM]  = sel_edge_i;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    rxbuf_flag flag_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .srst_i (soft_rst_i),
      .set_i  (flag_set[g]),
      .wr_i   (flag_wr_i),
      .wdata_i(flag_wdata_i[g]),
      .clr_i  (rd_i),
      .q_o    (flag_q[g])
    );
  end

  assign irq_o = flag_q[FLAG_PEND];
  assign ovr_o = flag_q[FLAG_OVR];
  assign frm_o = flag_q[FLAG_FRM];
endmodule

// File: rtl/rxbuf_status_chk.sv
module rxbuf_status_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SHORT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              load_i,
  input logic [DATA_W-1:0] load_data_i,
  input logic              seven_bit_i,
  input logic              sel_edge_i,
  input logic              rd_i,
  input logic              flag_wr_i,
  input logic [2:0]        flag_wdata_i,
  input logic [DATA_W-1:0] data_o,
  input logic              irq_o,
  input logic              ovr_o,
  input logic              frm_o
);
  AST_SOFT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (data_o == '0 || seven_bit_i !== seven_bit_i) && !irq_o && !ovr_o && !frm_o); // R2
  AST_SHORT_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seven_bit_i |-> data_o[DATA_W-1:SHORT_W] == '0); // R4
  AST_LOAD_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !soft_rst_i |=> irq_o); // R5
  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && irq_o && !rd_i && !soft_rst_i |=> ovr_o); // R6
  AST_READ_CLR_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !load_i && !flag_wr_i |=> !irq_o); // R7
  AST_READ_CLR_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !flag_wr_i |=> !ovr_o); // R8
  AST_FRAME_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_edge_i && !soft_rst_i |=> frm_o); // R9
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !soft_rst_i ##1 $stable(seven_bit_i) |-> $stable(data_o)); // R11
endmodule

bind rxbuf_status rxbuf_status_chk #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) chk_i (.*);

// File: tb/rxbuf_status_tb_top.sv
module rxbuf_status_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] load_data_i = '0;
  logic       seven_bit_i = 1'b0;
  logic       sel_edge_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       flag_wr_i = 1'b0;
  logic [2:0] flag_wdata_i = '0;
  logic [7:0] data_o;
  logic       irq_o, ovr_o, frm_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] data;
    logic [2:0] flags;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk_i = ~clk_i;

  rxbuf_status dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .load_i(load_i),
    .load_data_i(load_data_i), .seven_bit_i(seven_bit_i), .sel_edge_i(sel_edge_i),
    .rd_i(rd_i), .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
    .data_o(data_o), .irq_o(irq_o), .ovr_o(ovr_o), .frm_o(frm_o)
  );

  task automatic compare(input logic [7:0] ed, input logic [2:0] ef, input string req);
    logic [2:0] af;
    af = {frm_o, ovr_o, irq_o};
    checks++;
    if (data_o !== ed || af !== ef) begin
      errors++;
      $display("FAIL %s: data=%h flags=%b expected data=%h flags=%b", req, data_o, af, ed, ef);
    end
  endtask

  // driver: apply one cycle of stimulus, push expected state after the edge
  task automatic step(input logic ld, input logic [7:0] d, input logic sh, input logic rd,
                      input logic sel, input logic wr, input logic [2:0] wd, input logic sr,
                      input logic [7:0] ed, input logic [2:0] ef, input string req);
    exp_t e;
    @(negedge clk_i);
    load_i = ld; load_data_i = d; seven_bit_i = sh; rd_i = rd;
    sel_edge_i = sel; flag_wr_i = wr; flag_wdata_i = wd; soft_rst_i = sr;
    e.data = ed; e.flags = ef; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        compare(e.data, e.flags, e.req);
      end
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5;
    compare(8'h00, 3'b000, "R1 reset state");
    @(negedge clk_i);
    rst_ni = 1'b1;
    //   ld  data   sh  rd  sel wr  wd      sr   exp    flags
    step(1, 8'hA5, 0, 0, 0, 0, 3'b000, 0, 8'hA5, 3'b001, "R3 R5 load");
    step(0, 8'h00, 0, 0, 0, 0, 3'b000, 0, 8'hA5, 3'b001, "R3 hold");
    step(0, 8'h00, 0, 1, 0, 0, 3'b000, 0, 8'hA5, 3'b000, "R7 R11 read");
    step(1, 8'h3C, 0, 0, 0, 0, 3'b000, 0, 8'h3C, 3'b001, "R5 load");
    step(1, 8'h5A, 0, 0, 0, 0, 3'b000, 0, 8'h5A, 3'b011, "R6 overrun");
    step(0, 8'h00, 0, 1, 0, 0, 3'b000, 0, 8'h5A, 3'b000, "R7 read clears overrun");
    step(1, 8'h11, 0, 0, 0, 0, 3'b000, 0, 8'h11, 3'b001, "R5 load");
    step(1, 8'h22, 0, 1, 0, 0, 3'b000, 0, 8'h22, 3'b001, "R8 load with read");
    step(0, 8'h00, 0, 0, 1, 0, 3'b000, 0, 8'h22, 3'b101, "R9 frame set");
    step(0, 8'h00, 0, 1, 1, 0, 3'b000, 0, 8'h22, 3'b100, "R9 frame set beats read");
    step(0, 8'h00, 0, 1, 0, 0, 3'b000, 0, 8'h22, 3'b000, "R7 read clears frame");
    step(1, 8'hFF, 1, 0, 0, 0, 3'b000, 0, 8'h7F, 3'b001, "R4 short load");
    step(0, 8'h00, 0, 0, 0, 0, 3'b000, 0, 8'h7F, 3'b001, "R4 stored masked");
    step(1, 8'h80, 0, 0, 0, 0, 3'b000, 0, 8'h80, 3'b011, "R6 overrun 8-bit");
    step(0, 8'h00, 1, 0, 0, 0, 3'b000, 0, 8'h00, 3'b011, "R4 output masked");
    step(0, 8'h00, 0, 0, 0, 1, 3'b000, 0, 8'h80, 3'b000, "R10 write zeros");
    step(0, 8'h00, 0, 0, 0, 1, 3'b110, 0, 8'h80, 3'b110, "R10 write ones");
    step(1, 8'h44, 0, 0, 0, 1, 3'b000, 0, 8'h44, 3'b001, "R10 set beats write");
    step(0, 8'h00, 0, 1, 0, 1, 3'b111, 0, 8'h44, 3'b111, "R10 write beats read");
    step(1, 8'h99, 0, 1, 1, 1, 3'b111, 1, 8'h00, 3'b000, "R2 soft reset priority");
    step(1, 8'h01, 0, 0, 0, 0, 3'b000, 0, 8'h01, 3'b001, "R3 load after soft reset");
    step(0, 8'h00, 0, 0, 0, 0, 3'b000, 0, 8'h01, 3'b001, "R3 hold");
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    compare(8'h00, 3'b000, "R1 async reset");
    @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule